// File: doc/BRIEF.md
# Routed Vector Interrupt Controller

This block gathers 256 edge-triggered interrupt lines for one node and steers each one to a chosen core and a chosen CPU interrupt pin. A rising edge on a line sets that line's pending bit. Software reads the pending bits and clears them by writing ones. Each line has its own enable bit and its own route byte. The low nibble of the route byte is a core bitmap. Each group of 32 lines has a pin-map byte that picks the output pins.

Every core has a small vector of interrupt pins. Core `c`, pin `p` is asserted in the cycle after a line meets four conditions: it is pending, it is enabled, its route bitmap has bit `c` set, and its group's pin-map byte has bit `p` set. Software reaches all state through a 32-bit word port. Each write carries a byte-keep mask, and reads are combinational.

Top module: `vec_route_intc`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is all zero.
- R2: A 0-to-1 transition on `vec_in[v]` sets pending bit `v` whether or not `v` is enabled. A level that is held high does not set the bit again after it has been cleared.
- R3: Pending bits are read at 0x1800 + 4*k, where word k holds lines 32k..32k+31 and bit `v&31` holds line `v`. Each 64-bit status word is therefore the pair of adjacent 32-bit words, low half first.
- R4: Writing a pending word clears every bit written as 1 and leaves every bit written as 0 unchanged. A rising edge in the same cycle as a clear of that bit wins, and the bit stays set.
- R5: Enable word k sits at 0x1600 + 4*k, and bit `v&31` of word `v>>5` enables line `v`. A line that is disabled latches but does not drive any pin.
- R6: The route byte of line `v` is byte lane `v&3` of the word at 0x1C00 + 4*(`v>>2`). Bit `c` of bits 3:0 delivers the line to core `c`. Several set bits deliver it to several cores.
- R7: The pin-map byte of group `g = v>>5` is byte lane `g&3` of the word at 0x14C0 + 4*(`g>>2`). Bit `p` drives pin `p`. A zero byte drives no pin.
- R8: Bit `b` of `reg_keep` set during a write leaves byte `b` of the target word unchanged. This applies to every window, including the pending clear.
- R9: Words at 0x1680 + 4*k (k = 0..7) can be written and read back, and they have no effect on `irq_out`.
- R10: Bits 7:4 of a route byte are stored and read back, and they play no part in delivery.
- R11: `irq_out[c*8+p]` is registered: it reflects the register state of the previous cycle. A read of an unmapped address returns zero, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_in | input | 256 | Interrupt lines, edge-sensitive |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 16 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_keep | input | 4 | Per-byte keep mask (1 = keep old byte) |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 32 | Pin outputs, index core*8 + pin |

## Verification
The assertions assume that `vec_in` is synchronous to `clk` and is stable between edges. They also assume that `reg_addr` is word aligned whenever `reg_wr` is high. The bench meets both conditions: it changes every input only on the falling edge and only ever issues aligned addresses. Holding rules then concern only the pending and delivery state, such as bits that stay set until a clear and pins that stay low while nothing enabled is pending. These rules stay valid for any write sequence that the bench issues.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned INTC_AW  = 16;
  localparam int unsigned GRP_SIZE = 32;

  localparam logic [INTC_AW-1:0] PMAP_BASE  = 16'h14C0;
  localparam logic [INTC_AW-1:0] EN_BASE    = 16'h1600;
  localparam logic [INTC_AW-1:0] SPARE_BASE = 16'h1680;
  localparam logic [INTC_AW-1:0] PEND_BASE  = 16'h1800;
  localparam logic [INTC_AW-1:0] ROUTE_BASE = 16'h1C00;

  // Bits that a write may change, from the keep mask (1 = keep byte).
  function automatic logic [31:0] lane_bits(input logic [3:0] keep);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = keep[b] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] merge_word(input logic [31:0] cur,
                                             input logic [31:0] nxt,
                                             input logic [3:0]  keep);
    return (cur & ~lane_bits(keep)) | (nxt & lane_bits(keep));
  endfunction

  // True when addr falls on a word inside a window of nwords words.
  function automatic logic in_window(input logic [INTC_AW-1:0] addr,
                                     input logic [INTC_AW-1:0] base,
                                     input int unsigned nwords);
    logic [INTC_AW-1:0] off;
    off = addr - base;
    return (addr >= base) && (32'(off) < 4 * nwords) && (addr[1:0] == 2'b00);
  endfunction

  function automatic logic [INTC_AW-1:0] word_off(input logic [INTC_AW-1:0] addr,
                                                  input logic [INTC_AW-1:0] base);
    logic [INTC_AW-1:0] off;
    off = addr - base;
    return off >> 2;
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [INTC_AW-1:0]   addr,
  input  logic [31:0]          wdata,
  input  logic [3:0]           keep,
  output logic [NUM_VEC-1:0]   en_q,
  output logic [NUM_VEC*8-1:0] route_q,
  output logic [(NUM_VEC/GRP_SIZE)*8-1:0] pmap_q,
  output logic [31:0]          rdata
);
  localparam int unsigned NGRP  = NUM_VEC / GRP_SIZE;
  localparam int unsigned NRW   = NUM_VEC / 4;
  localparam int unsigned NPW   = (NGRP + 3) / 4;
  localparam int unsigned GIW   = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int unsigned RIW   = (NRW > 1) ? $clog2(NRW) : 1;
  localparam int unsigned PIW   = (NPW > 1) ? $clog2(NPW) : 1;

  logic [31:0] en_w    [NGRP];
  logic [31:0] spare_w [NGRP];
  logic [31:0] rt_w    [NRW];
  logic [31:0] pm_w    [NPW];

  logic hit_en, hit_sp, hit_rt, hit_pm;
  logic [GIW-1:0] en_i, sp_i;
  logic [RIW-1:0] rt_i;
  logic [PIW-1:0] pm_i;

  always_comb begin
    hit_en = in_window(addr, EN_BASE, NGRP);
    hit_sp = in_window(addr, SPARE_BASE, NGRP);
    hit_rt = in_window(addr, ROUTE_BASE, NRW);
    hit_pm = in_window(addr, PMAP_BASE, NPW);
    en_i   = GIW'(word_off(addr, EN_BASE));
    sp_i   = GIW'(word_off(addr, SPARE_BASE));
    rt_i   = RIW'(word_off(addr, ROUTE_BASE));
    pm_i   = PIW'(word_off(addr, PMAP_BASE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NGRP; i++) begin
        en_w[i]    <= '0;
        spare_w[i] <= '0;
      end
      for (int i = 0; i < NRW; i++) rt_w[i] <= '0;
      for (int i = 0; i < NPW; i++) pm_w[i] <= '0;
    end else if (wr) begin
      if (hit_en) en_w[en_i]    <= merge_word(en_w[en_i], wdata, keep);
      if (hit_sp) spare_w[sp_i] <= merge_word(spare_w[sp_i], wdata, keep);
      if (hit_rt) rt_w[rt_i]    <= merge_word(rt_w[rt_i], wdata, keep);
      if (hit_pm) pm_w[pm_i]    <= merge_word(pm_w[pm_i], wdata, keep);
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_en) rdata = en_w[en_i];
    if (hit_sp) rdata = spare_w[sp_i];
    if (hit_rt) rdata = rt_w[rt_i];
    if (hit_pm) rdata = pm_w[pm_i];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_en
    assign en_q[g*32 +: 32] = en_w[g];
  end
  for (genvar r = 0; r < NRW; r++) begin : g_rt
    assign route_q[r*32 +: 32] = rt_w[r];
  end
  for (genvar g = 0; g < NGRP; g++) begin : g_pm
    assign pmap_q[g*8 +: 8] = pm_w[g/4][(g%4)*8 +: 8];
  end
endmodule

// File: rtl/intc_pend.sv
module intc_pend
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] vec_in,
  input  logic               wr,
  input  logic [INTC_AW-1:0] addr,
  input  logic [31:0]        wdata,
  input  logic [3:0]         keep,
  output logic [NUM_VEC-1:0] pend_q,
  output logic [NUM_VEC-1:0] rise,
  output logic [NUM_VEC-1:0] clr_vec,
  output logic [31:0]        rdata
);
  localparam int unsigned NW  = NUM_VEC / GRP_SIZE;
  localparam int unsigned WIW = (NW > 1) ? $clog2(NW) : 1;

  logic [NUM_VEC-1:0] prev_q;
  logic               hit;
  logic [WIW-1:0]     wi;

  always_comb begin
    hit = in_window(addr, PEND_BASE, NW);
    wi  = WIW'(word_off(addr, PEND_BASE));
  end

  assign rise = vec_in & ~prev_q;

  always_comb begin
    clr_vec = '0;
    if (wr && hit) clr_vec[wi*32 +: 32] = wdata & lane_bits(keep);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= vec_in;
      pend_q <= (pend_q & ~clr_vec) | rise;
    end
  end

  assign rdata = hit ? pend_q[wi*32 +: 32] : 32'h0;
endmodule

// File: rtl/intc_deliver.sv
module intc_deliver
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned NUM_PIN  = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_VEC-1:0]             pend_q,
  input  logic [NUM_VEC-1:0]             en_q,
  input  logic [NUM_VEC*8-1:0]           route_q,
  input  logic [(NUM_VEC/GRP_SIZE)*8-1:0] pmap_q,
  output logic [NUM_VEC-1:0]             pend_act,
  output logic [NUM_CORE*NUM_PIN-1:0]    irq_q
);
  localparam int unsigned NGRP = NUM_VEC / GRP_SIZE;

  logic [NUM_VEC-1:0]       core_col [NUM_CORE];
  logic [NGRP*NUM_CORE-1:0] grp_hit;
  logic [NUM_CORE*NUM_PIN-1:0] irq_n;

  assign pend_act = pend_q & en_q;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      assign core_col[c][v] = route_q[v*8 + c];
    end
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign grp_hit[g*NUM_CORE + c] =
        |(pend_act[g*GRP_SIZE +: GRP_SIZE] & core_col[c][g*GRP_SIZE +: GRP_SIZE]);
    end
  end

  always_comb begin
    irq_n = '0;
    for (int g = 0; g < NGRP; g++)
      for (int c = 0; c < NUM_CORE; c++)
        for (int p = 0; p < NUM_PIN; p++)
          irq_n[c*NUM_PIN + p] = irq_n[c*NUM_PIN + p] |
                                 (grp_hit[g*NUM_CORE + c] & pmap_q[g*8 + p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_n;
  end
endmodule

// File: rtl/vec_route_intc.sv
module vec_route_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 256,
  parameter int unsigned NUM_CORE = 4,
  parameter int unsigned NUM_PIN  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_VEC-1:0]          vec_in,
  input  logic                        reg_wr,
  input  logic [INTC_AW-1:0]          reg_addr,
  input  logic [31:0]                 reg_wdata,
  input  logic [3:0]                  reg_keep,
  output logic [31:0]                 reg_rdata,
  output logic [NUM_CORE*NUM_PIN-1:0] irq_out
);
  localparam int unsigned NGRP = NUM_VEC / GRP_SIZE;

  logic [NUM_VEC-1:0]   pend_q, en_q, rise, clr_vec, pend_act;
  logic [NUM_VEC*8-1:0] route_q;
  logic [NGRP*8-1:0]    pmap_q;
  logic [31:0]          rd_cfg, rd_pend;

  intc_cfg_regs #(.NUM_VEC(NUM_VEC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .keep(reg_keep), .en_q(en_q), .route_q(route_q), .pmap_q(pmap_q), .rdata(rd_cfg)
  );

  intc_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst_n(rst_n), .vec_in(vec_in), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .keep(reg_keep), .pend_q(pend_q), .rise(rise),
    .clr_vec(clr_vec), .rdata(rd_pend)
  );

  intc_deliver #(.NUM_VEC(NUM_VEC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN)) u_dlv (
    .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .en_q(en_q), .route_q(route_q),
    .pmap_q(pmap_q), .pend_act(pend_act), .irq_q(irq_out)
  );

  // Windows are disjoint, so at most one source is nonzero.
  assign reg_rdata = rd_cfg | rd_pend;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned NOUT    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] rise,
  input logic [NUM_VEC-1:0] clr_vec,
  input logic [NUM_VEC-1:0] pend_act,
  input logic [NOUT-1:0]    irq_out
);
  // R2
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pend_q & $past(rise)) == $past(rise)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~rise)) |=> ((pend_q & $past(clr_vec & ~rise)) == '0));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_q) |=> (($past(pend_q & ~clr_vec) & ~pend_q) == '0));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_act == '0) |=> (irq_out == '0));
endmodule

bind vec_route_intc intc_chk #(.NUM_VEC(NUM_VEC), .NOUT(NUM_CORE*NUM_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .rise(rise), .clr_vec(clr_vec),
  .pend_act(pend_act), .irq_out(irq_out)
);

// File: tb/vec_route_intc_bench.sv
`timescale 1ns/1ps
module vec_route_intc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] vec_in = '0;
  logic         reg_wr = 1'b0;
  logic [15:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [3:0]   reg_keep = '0;
  logic [31:0]  reg_rdata;
  logic [31:0]  irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  vec_route_intc u_vec_route_intc (
    .clk(clk), .rst_n(rst_n), .vec_in(vec_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_keep(reg_keep), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // Table: line, route byte, pin-map byte, enable, expected irq_out (bit core*8+pin).
  localparam int NT = 7;
  localparam int unsigned T_VEC [NT] = '{0, 37, 255, 100, 64, 200, 150};
  localparam logic [7:0]  T_RT  [NT] = '{8'h01, 8'h04, 8'h08, 8'h03, 8'h02, 8'hF1, 8'h02};
  localparam logic [7:0]  T_PM  [NT] = '{8'h01, 8'h02, 8'h80, 8'h10, 8'h04, 8'h08, 8'h00};
  localparam logic        T_EN  [NT] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [31:0] T_EXP [NT] = '{32'h0000_0001, 32'h0002_0000, 32'h8000_0000,
                                         32'h0000_1010, 32'h0, 32'h0000_0008, 32'h0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [15:0] a, input logic [31:0] d, input logic [3:0] k);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_keep = k;
    @(negedge clk);
    reg_wr = 1'b0; reg_keep = '0;
  endtask

  task automatic rd32(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int unsigned v);
    @(negedge clk); vec_in[v] = 1'b1;
    @(negedge clk);
    @(negedge clk); vec_in[v] = 1'b0;
  endtask

  function automatic logic [3:0] keep_lane(input int unsigned lane);
    return ~(4'b0001 << lane);
  endfunction

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq_out after reset", irq_out, 32'h0);
    rd32(16'h1600, rv); check("R1 enable word", rv, 32'h0);
    rd32(16'h1C00, rv); check("R1 route word", rv, 32'h0);
    rd32(16'h1800, rv); check("R1 pending word", rv, 32'h0);

    // Table walk: R3 R5 R6 R7 R10
    for (int t = 0; t < NT; t++) begin
      int unsigned v, g;
      v = T_VEC[t]; g = v >> 5;
      wr32(16'h14C0 + 16'(4 * (g >> 2)), 32'(T_PM[t]) << (8 * (g & 3)), keep_lane(g & 3));
      wr32(16'h1C00 + 16'(4 * (v >> 2)), 32'(T_RT[t]) << (8 * (v & 3)), keep_lane(v & 3));
      wr32(16'h1600 + 16'(4 * g), 32'(T_EN[t]) << (v & 31), 4'h0);
      pulse(v);
      @(negedge clk);
      check($sformatf("R5 R6 R7 table %0d irq_out", t), irq_out, T_EXP[t]);
      rd32(16'h1800 + 16'(4 * g), rv);
      check($sformatf("R3 table %0d pending bit", t), rv, 32'h1 << (v & 31));
      rd32(16'h1C00 + 16'(4 * (v >> 2)), rv);
      check($sformatf("R10 table %0d route readback", t), rv, 32'(T_RT[t]) << (8 * (v & 3)));
      wr32(16'h1800 + 16'(4 * g), 32'hFFFF_FFFF, 4'h0);
      wr32(16'h1600 + 16'(4 * g), 32'h0, 4'h0);
      wr32(16'h1C00 + 16'(4 * (v >> 2)), 32'h0, 4'h0);
      wr32(16'h14C0 + 16'(4 * (g >> 2)), 32'h0, 4'h0);
      @(negedge clk);
      check($sformatf("R4 table %0d irq after clear", t), irq_out, 32'h0);
    end

    // R8 byte keep mask
    wr32(16'h1C00, 32'hAABB_CCDD, 4'h0);
    wr32(16'h1C00, 32'h1122_3344, 4'b0101);
    rd32(16'h1C00, rv); check("R8 keep mask merge", rv, 32'h11BB_33DD);
    wr32(16'h1C00, 32'h0, 4'h0);

    // R4 partial clear
    @(negedge clk); vec_in[0] = 1'b1; vec_in[1] = 1'b1;
    @(negedge clk); vec_in[0] = 1'b0; vec_in[1] = 1'b0;
    wr32(16'h1800, 32'h1, 4'h0);
    rd32(16'h1800, rv); check("R4 write-one clears only ones", rv, 32'h2);
    // R8 keep on the pending clear
    wr32(16'h1800, 32'h2, 4'b0001);
    rd32(16'h1800, rv); check("R8 kept byte not cleared", rv, 32'h2);
    wr32(16'h1800, 32'hFFFF_FFFF, 4'h0);

    // R4 edge and clear in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 16'h1800; reg_wdata = 32'h4; reg_keep = '0; vec_in[2] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; vec_in[2] = 1'b0;
    rd32(16'h1800, rv); check("R4 edge wins over clear", rv, 32'h4);
    wr32(16'h1800, 32'hFFFF_FFFF, 4'h0);

    // R2 held level does not re-latch; latches while disabled
    @(negedge clk); vec_in[9] = 1'b1;
    @(negedge clk);
    rd32(16'h1800, rv); check("R2 latch while disabled", rv, 32'h200);
    wr32(16'h1800, 32'h200, 4'h0);
    repeat (3) @(negedge clk);
    rd32(16'h1800, rv); check("R2 held level no relatch", rv, 32'h0);
    vec_in[9] = 1'b0;

    // R3 line 63 in the upper half of the first 64-bit word
    pulse(63);
    rd32(16'h1804, rv); check("R3 line 63 position", rv, 32'h8000_0000);
    wr32(16'h1804, 32'hFFFF_FFFF, 4'h0);

    // R9 spare words
    wr32(16'h1684, 32'hDEAD_BEEF, 4'h0);
    rd32(16'h1684, rv); check("R9 spare readback", rv, 32'hDEAD_BEEF);
    @(negedge clk); check("R9 spare no effect", irq_out, 32'h0);

    // R11 unmapped address
    wr32(16'h0100, 32'hFFFF_FFFF, 4'h0);
    rd32(16'h0100, rv); check("R11 unmapped reads zero", rv, 32'h0);

    // R11 output is one cycle behind the enabling write
    wr32(16'h14C0, 32'h0000_0001, 4'h0);
    wr32(16'h1C00, 32'h0000_0100, 4'h0);
    pulse(5 - 4);
    check("R11 before enable", irq_out, 32'h0);
    wr32(16'h1600, 32'h2, 4'h0);
    check("R11 same cycle as enable commit", irq_out, 32'h0);
    @(negedge clk);
    check("R11 one cycle later", irq_out, 32'h0000_0001);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule